// File: doc/BRIEF.md
# Burst Register Window Collector

This block is a write-only bus slave that sits in front of peripheral registers which take multi-word requests. Each such register owns a reserved address window. Any write that lands inside a window is taken as the next word of that register's pending request, whatever its offset inside the window. Once four words have arrived, the assembled request is offered to the peripheral on a valid/ready output, word 0 being the first word that arrived.

Software and bus masters may issue the words as a burst or as separate single beats, and the addresses inside the window may be incrementing, fixed or arbitrary. Only arrival order counts. While an assembled request waits for its consumer, writes to that window are held off by keeping the write-ready low, and writes to other windows keep flowing. A write that matches no window is accepted and answered with an error response.

Top module: `burst_window_slave`

## Requirements
- R1: A synchronous active-low reset clears every request-valid output and the response-valid output, and discards any partly assembled request, so the next four writes to a window form a complete request of their own.
- R2: Window i covers byte addresses from WIN_BASE + i*WIN_STRIDE up to but excluding WIN_BASE + i*WIN_STRIDE + WIN_SPAN (defaults: base 0x10000, stride 0x200, span 0x100, two windows, 20-bit address).
- R3: The offset of a write inside its window has no effect on where the word is placed; the n-th accepted write after a request boundary becomes word n (counting from 0), held in bits [32n+31:32n] of that window's slice of req_data, and window i's slice is bits [128i+127:128i].
- R4: The request-valid output of a window rises in the cycle after its fourth accepted write and not earlier.
- R5: While a window's request-valid is high, wr_ready is low for writes addressed to that window and no write to it is accepted; writes to other windows are still accepted.
- R6: A request-valid output, with its data, stays unchanged until req_ready is high in the same cycle, and falls in the following cycle.
- R7: A write that hits no window sees wr_ready high, gets rsp_err high one cycle after acceptance, and does not change any window's word count.
- R8: Every accepted write produces rsp_valid high for exactly one cycle, one cycle after the acceptance edge, with rsp_err low for a write that hits a window.
- R9: Each window assembles its request independently; writes interleaved between windows build separate requests in their own arrival order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat can be taken this cycle |
| wr_addr | input | ADDR_W | Byte address of the beat |
| wr_data | input | DATA_W | Write data of the beat |
| rsp_valid | output | 1 | Response for the beat accepted one cycle earlier |
| rsp_err | output | 1 | That beat hit no window |
| req_valid | output | NUM_WIN | Assembled request ready, one bit per window |
| req_ready | input | NUM_WIN | Consumer takes the request, one bit per window |
| req_data | output | NUM_WIN*WORDS*DATA_W | Assembled requests, word 0 lowest in each slice |

## Verification
The assertions watch, on every cycle, that a held request keeps its valid and data until the consumer takes it and then drops, that each accepted beat gets exactly one response a cycle later, that an error response never appears without a response, that back-pressure only occurs while some request is pending, and that reset clears the outputs. What they cannot show is that words land in arrival order regardless of offset, that a miss leaves the count alone, or that a blocked write never sneaks into a later request; the bench shows these by sweeping offset patterns over both windows and comparing every assembled word with a value computed from the request and word number.

// File: rtl/burst_window_pkg.sv
// burst_window_pkg
// Shared constants and helpers for the burst register window collector.
// Assumes addresses fit in 32 bits.
package burst_window_pkg;

    typedef logic [31:0] addr32_t;

    // Lower bound of window number idx.
    function automatic addr32_t window_lo(input addr32_t base, input addr32_t stride,
                                          input int unsigned idx);
        return base + addr32_t'(idx) * stride;
    endfunction

    // True when addr lies in [lo, lo + span).
    function automatic logic in_window(input addr32_t addr, input addr32_t lo,
                                       input addr32_t span);
        return (addr >= lo) && (addr < lo + span);
    endfunction

    // Width of a counter that indexes n items, at least one bit.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bws_window_decode.sv
// bws_window_decode
// Compares the beat address against every reserved window and reports a
// one-hot hit vector plus a miss flag. Purely combinational.
// Assumes windows do not overlap and ADDR_W <= 32.
module bws_window_decode
    import burst_window_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned NUM_WIN    = 2,
    parameter logic [31:0] WIN_BASE   = 32'h0001_0000,
    parameter logic [31:0] WIN_STRIDE = 32'h0000_0200,
    parameter logic [31:0] WIN_SPAN   = 32'h0000_0100
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] hit,
    output logic               miss
);

    addr32_t addr_ext;

    // Widen the address once for all comparisons.
    always_comb addr_ext = addr32_t'(addr);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        localparam addr32_t LO = window_lo(WIN_BASE, WIN_STRIDE, i);
        // Range compare for window i.
        always_comb hit[i] = in_window(addr_ext, LO, WIN_SPAN);
    end

    // A miss is a beat that no window claims.
    always_comb miss = ~|hit;

endmodule

// File: rtl/bws_word_assembler.sv
// bws_word_assembler
// Gathers WORDS data words for one window in arrival order. The n-th
// write after a request boundary goes to slot n. After the last slot is
// filled the request is held and offered until the consumer accepts it.
// Assumes wr_en is only raised while busy is low.
module bws_word_assembler
    import burst_window_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORDS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [DATA_W-1:0]       wr_data,
    output logic                    busy,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [WORDS*DATA_W-1:0] req_data
);

    localparam int unsigned CNT_W = idx_width(WORDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              full_q;
    logic              take;
    logic [DATA_W-1:0] slot_q [WORDS];

    // A beat is taken only when no finished request is waiting.
    always_comb take = wr_en & ~full_q;

    // Word counter and request-held flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (full_q && req_ready) begin
                full_q <= 1'b0;
            end
            if (take) begin
                if (cnt_q == LAST) begin
                    cnt_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        // Capture the beat into the slot selected by the arrival count.
        always_ff @(posedge clk) begin
            if (take && (cnt_q == CNT_W'(k))) begin
                slot_q[k] <= wr_data;
            end
        end
        // Lay the slot out in the flat request word.
        always_comb req_data[k*DATA_W +: DATA_W] = slot_q[k];
    end

    // Hold state drives both the back-pressure and the offer.
    always_comb begin
        busy      = full_q;
        req_valid = full_q;
    end

endmodule

// File: rtl/bws_resp_reg.sv
// bws_resp_reg
// Registers a one-cycle response for every accepted write beat and marks
// beats that hit no window as errors.
// Assumes beat_miss is only meaningful when beat_accept is high.
module bws_resp_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_accept,
    input  logic beat_miss,
    output logic rsp_valid,
    output logic rsp_err
);

    // One response per accepted beat, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= beat_accept;
            rsp_err   <= beat_accept & beat_miss;
        end
    end

endmodule

// File: rtl/burst_window_slave.sv
// burst_window_slave
// Write-only slave that turns writes into fixed-size requests, one
// assembler per reserved window. Offsets inside a window are ignored;
// arrival order sets word position. Writes to a window whose request is
// pending are back-pressured; writes outside every window get an error.
// Assumes address and data arrive together on one beat.
module burst_window_slave
    import burst_window_pkg::*;
#(
    parameter int unsigned ADDR_W     = 20,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned WORDS      = 4,
    parameter int unsigned NUM_WIN    = 2,
    parameter logic [31:0] WIN_BASE   = 32'h0001_0000,
    parameter logic [31:0] WIN_STRIDE = 32'h0000_0200,
    parameter logic [31:0] WIN_SPAN   = 32'h0000_0100
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_valid,
    output logic                            wr_ready,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output logic                            rsp_valid,
    output logic                            rsp_err,
    output logic [NUM_WIN-1:0]              req_valid,
    input  logic [NUM_WIN-1:0]              req_ready,
    output logic [NUM_WIN*WORDS*DATA_W-1:0] req_data
);

    localparam int unsigned REQ_W = WORDS * DATA_W;

    logic [NUM_WIN-1:0] hit;
    logic               miss;
    logic [NUM_WIN-1:0] busy;
    logic [NUM_WIN-1:0] win_wr;
    logic               accept;

    bws_window_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_WIN   (NUM_WIN),
        .WIN_BASE  (WIN_BASE),
        .WIN_STRIDE(WIN_STRIDE),
        .WIN_SPAN  (WIN_SPAN)
    ) u_decode (
        .addr(wr_addr),
        .hit (hit),
        .miss(miss)
    );

    // Ready unless the addressed window still holds an unclaimed request.
    always_comb begin
        wr_ready = miss | (|(hit & ~busy));
        accept   = wr_valid & wr_ready;
        win_wr   = {NUM_WIN{wr_valid}} & hit & ~busy;
    end

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        bws_word_assembler #(
            .DATA_W(DATA_W),
            .WORDS (WORDS)
        ) u_asm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (win_wr[i]),
            .wr_data  (wr_data),
            .busy     (busy[i]),
            .req_valid(req_valid[i]),
            .req_ready(req_ready[i]),
            .req_data (req_data[i*REQ_W +: REQ_W])
        );
    end

    bws_resp_reg u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_accept(accept),
        .beat_miss  (miss),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err)
    );

endmodule

// File: rtl/burst_window_slave_chk.sv
// burst_window_slave_chk
// Cycle-level checks on the collector's ports, bound to every instance.
module burst_window_slave_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned WORDS   = 4,
    parameter int unsigned NUM_WIN = 2
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            wr_valid,
    input logic                            wr_ready,
    input logic                            rsp_valid,
    input logic                            rsp_err,
    input logic [NUM_WIN-1:0]              req_valid,
    input logic [NUM_WIN-1:0]              req_ready,
    input logic [NUM_WIN*WORDS*DATA_W-1:0] req_data
);

    localparam int unsigned REQ_W = WORDS * DATA_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (req_valid == '0) && !rsp_valid) // R1
        else $error("reset did not clear outputs");

    AST_ONLY_PENDING_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> (|req_valid)) // R5
        else $error("stall without a pending request");

    AST_BLOCKED_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> !rsp_valid) // R5
        else $error("blocked beat produced a response");

    AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_valid) // R7
        else $error("error without response");

    AST_ACCEPT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> rsp_valid) // R8
        else $error("accepted beat lacked a response");

    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !rsp_valid) // R8
        else $error("response without a beat");

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && !req_ready[i]) |=>
                (req_valid[i] && $stable(req_data[i*REQ_W +: REQ_W]))) // R6
            else $error("request changed while waiting");

        AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[i] && req_ready[i]) |=> !req_valid[i]) // R6
            else $error("request stayed after handshake");
    end

endmodule

bind burst_window_slave burst_window_slave_chk #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .NUM_WIN(NUM_WIN)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rsp_valid(rsp_valid),
    .rsp_err  (rsp_err),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_data (req_data)
);

// File: tb/burst_window_slave_bench.sv
module burst_window_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 2;
    localparam int WD = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic              wr_ready;
    logic [19:0]       wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rsp_valid;
    logic              rsp_err;
    logic [NW-1:0]     req_valid;
    logic [NW-1:0]     req_ready = '0;
    logic [NW*WD*32-1:0] req_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    burst_window_slave u_burst_window_slave (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .req_valid(req_valid), .req_ready(req_ready),
        .req_data(req_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] wbase(input int w);
        return 20'h10000 + 20'(w) * 20'h200;
    endfunction

    function automatic logic [19:0] offs(input int p, input int k);
        return 20'(((p * 3 + k * (p + 1) * 5) % 64) * 4);
    endfunction

    function automatic logic [31:0] word_of(input int w, input int p, input int k);
        return 32'hA500_0000 ^ (32'(w) << 20) ^ (32'(p) << 8) ^ 32'(k * 17 + 1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One beat; returns ready seen and error response; checks the response.
    task automatic beat(input logic [19:0] a, input logic [31:0] d,
                        output logic rdy, output logic err);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        #1 rdy = wr_ready;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
        err = rsp_err;
        chk(rsp_valid == rdy, "R8 response follows acceptance", 64'(rsp_valid), 64'(rdy));
    endtask

    // Write words k0..k1 of request p to window w at scattered offsets.
    task automatic send_words(input int w, input int p, input int k0, input int k1);
        logic rdy, err;
        for (int k = k0; k <= k1; k++) begin
            beat(wbase(w) + offs(p, k), word_of(w, p, k), rdy, err);
            chk(rdy == 1'b1 && err == 1'b0, "R2 hit accepted without error",
                64'({rdy, err}), 64'h2);
            if (k < WD - 1)
                chk(req_valid[w] == 1'b0, "R4 no valid before last word",
                    64'(req_valid[w]), 64'h0);
        end
    endtask

    // Check a complete request, then consume it.
    task automatic take_req(input int w, input int p);
        chk(req_valid[w] == 1'b1, "R4 valid after fourth word", 64'(req_valid[w]), 64'h1);
        for (int k = 0; k < WD; k++)
            chk(req_data[(w*WD+k)*32 +: 32] == word_of(w, p, k), "R3 word in arrival order",
                64'(req_data[(w*WD+k)*32 +: 32]), 64'(word_of(w, p, k)));
        req_ready[w] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_ready[w] = 1'b0;
        chk(req_valid[w] == 1'b0, "R6 valid falls after handshake", 64'(req_valid[w]), 64'h0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(req_valid == '0, "R1 request valid cleared", 64'(req_valid), 64'h0);
        chk(rsp_valid == 1'b0, "R1 response cleared", 64'(rsp_valid), 64'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic rdy, err;
        logic [19:0] miss_addr [6];
        miss_addr = '{20'h0FFFC, 20'h10100, 20'h101FC, 20'h10300, 20'h00000, 20'hFFFFC};

        do_reset();
        #1 chk(wr_ready == 1'b1, "R1 ready after reset", 64'(wr_ready), 64'h1);

        // Offset sweep over both windows.
        for (int p = 0; p < 8; p++)
            for (int w = 0; w < NW; w++) begin
                send_words(w, p, 0, WD - 1);
                take_req(w, p);
            end

        // R9: interleaved windows.
        for (int k = 0; k < WD; k++) begin
            beat(wbase(0) + offs(20, k), word_of(0, 20, k), rdy, err);
            beat(wbase(1) + offs(21, k), word_of(1, 21, k), rdy, err);
        end
        chk(req_valid == 2'b11, "R9 both windows complete", 64'(req_valid), 64'h3);
        take_req(0, 20);
        take_req(1, 21);

        // R5/R6: back-pressure while held.
        send_words(0, 30, 0, WD - 1);
        repeat (5) @(negedge clk);
        chk(req_valid[0] == 1'b1, "R6 valid held while not ready", 64'(req_valid[0]), 64'h1);
        beat(wbase(0) + 20'h8, 32'hDEAD_BEEF, rdy, err);
        chk(rdy == 1'b0, "R5 blocked write to held window", 64'(rdy), 64'h0);
        beat(wbase(1) + offs(32, 0), word_of(1, 32, 0), rdy, err);
        chk(rdy == 1'b1, "R5 other window still accepted", 64'(rdy), 64'h1);
        take_req(0, 30);
        send_words(0, 31, 0, WD - 1);
        take_req(0, 31);
        send_words(1, 32, 1, WD - 1);
        take_req(1, 32);

        // R7: misses leave the count alone.
        send_words(0, 40, 0, 1);
        foreach (miss_addr[j]) begin
            beat(miss_addr[j], 32'h0BAD_0000 + 32'(j), rdy, err);
            chk(rdy == 1'b1 && err == 1'b1, "R7 miss accepted with error",
                64'({rdy, err}), 64'h3);
        end
        chk(req_valid == '0, "R7 misses add no word", 64'(req_valid), 64'h0);
        beat(wbase(0) + 20'hFC, word_of(0, 40, 2), rdy, err);
        chk(err == 1'b0, "R2 last address of window hits", 64'(err), 64'h0);
        send_words(0, 40, 3, 3);
        take_req(0, 40);

        // R1: reset discards a partial request.
        send_words(0, 50, 0, 2);
        do_reset();
        send_words(0, 51, 0, WD - 1);
        take_req(0, 51);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule